// File: doc/BRIEF.md
# Register Window Decoder with Byte-Order Half Select

This block claims processor bus accesses that land in a 64 KB window of internal control registers and routes them to a small local register file. The window answers at a fixed default base of `0xF_FF1F_0000`. It also answers at a second base taken from a programmable base-pointer register, so after relocation the same register can be reached through two physical addresses. The local register file stands in for the real control registers. It holds a few 64-bit registers, a few 32-bit registers and the base pointer itself.

A 64-bit register can be accessed as one 64-bit access or as two 32-bit accesses. Which half a 32-bit access reaches depends on the byte-order input. Accesses of an undefined size or alignment are flagged with an error and write nothing. Addresses outside both windows are not claimed.

Each access is handled by a two-state machine. `ST_IDLE` accepts a request when `bus_valid` is high and moves to `ST_RESP`. All decoding, the write and the capture of the response happen on that accepting edge. `ST_RESP` presents the response for exactly one cycle and always returns to `ST_IDLE`. No request is accepted while the block is in `ST_RESP`.

Top module: `regwin_decoder`

## Requirements
- R1: After reset `resp_valid` is 0 and `bus_ready` is 1. All register contents are zero. The base pointer reads back as 0xFFF1F, which is the default base address bits [35:16].
- R2: An access with address bits [35:16] equal to 0xFFF1F is claimed (`resp_hit`=1). Address bits [15:0] form the register offset.
- R3: An access whose bits [35:16] match neither the default base nor the base pointer gives `resp_hit`=0, `resp_err`=0 and `resp_rdata`=0, and it writes nothing.
- R4: A 32-bit write to offset 0x200 loads `bus_wdata[19:0]` into the base pointer. A 32-bit read there returns the pointer zero-extended. The new base is used from the next access on.
- R5: After relocation, an offset under the default base and the same offset under the pointer base reach the same register.
- R6: The 64-bit registers sit at offsets 8*k, for k = 0..3. An aligned access with size code 3 (64 bits) reads or writes the whole register. Reads return data only when `bus_we`=0; a write returns 0.
- R7: With `big_endian`=1, a 32-bit access (size code 2) to a 64-bit register with offset bit 2 = 0 reaches bits [63:32], and with bit 2 = 1 it reaches bits [31:0]. The data travels on bus bits [31:0], and read bits [63:32] are 0.
- R8: With `big_endian`=0, the selection of R7 is reversed: offset bit 2 = 0 reaches bits [31:0], and bit 2 = 1 reaches bits [63:32].
- R9: The 32-bit registers sit at offset 0x100+4*j, for j = 0..3. They accept size code 2 only. Size codes 0 (8-bit), 1 (16-bit) and 3 (64-bit) raise `resp_err` and do not write.
- R10: A claimed access is an error with no write in two cases. The first is a misaligned access: size 1 with addr[0]≠0, size 2 with addr[1:0]≠0, or size 3 with addr[2:0]≠0. The second is an 8- or 16-bit access to a 64-bit register. An error response returns `resp_rdata`=0.
- R11: A request is accepted on an edge where `bus_valid` and `bus_ready` are both high. `resp_valid`, `resp_hit`, `resp_err` and `resp_rdata` are valid in the following cycle only. `bus_ready` is low in that cycle.
- R12: An in-window offset that maps to no register is claimed without error. It reads as 0, and a write to it is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present |
| bus_ready | output | 1 | Block can accept a request (state `ST_IDLE`) |
| bus_addr | input | 36 | Physical byte address |
| bus_size | input | 2 | Access size code: 0=8, 1=16, 2=32, 3=64 bits |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 64 | Write data; 32-bit data on bits [31:0] |
| big_endian | input | 1 | Byte order: 1 = big endian, 0 = little endian |
| resp_valid | output | 1 | Response cycle (state `ST_RESP`) |
| resp_hit | output | 1 | Access was claimed by a window |
| resp_err | output | 1 | Undefined size or alignment |
| resp_rdata | output | 64 | Read data |

## Verification
The assertions assume that `bus_valid`, `bus_size` and the low address bits are known, non-X values at every accepting edge after reset. Request fields matter only on the accepting edge. The bench drives all inputs on the falling clock edge and holds them until the next rising edge, so they are settled whenever the block samples them. It lowers `bus_valid` during the response cycle, and every request therefore sees a fresh `ST_IDLE` state.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        T_NONE = 2'd0,
        T_R64  = 2'd1,
        T_R32  = 2'd2,
        T_BPTR = 2'd3
    } target_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;

endpackage

// File: rtl/regwin_match.sv
module regwin_match #(
    parameter int ADDR_W = 36,
    parameter int WIN_W  = 16,
    parameter logic [ADDR_W-WIN_W-1:0] DEF_BASE = 'hFFF1F
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [ADDR_W-WIN_W-1:0] base_ptr,
    output logic                    hit,
    output logic [WIN_W-1:0]        offset
);
    logic [ADDR_W-WIN_W-1:0] page;

    // The window page is compared against both bases; either one claims it.
    assign page   = addr[ADDR_W-1:WIN_W];
    assign offset = addr[WIN_W-1:0];
    assign hit    = (page == DEF_BASE) || (page == base_ptr);
endmodule

// File: rtl/regwin_regfile.sv
module regwin_regfile #(
    parameter int N64 = 4,
    parameter int N32 = 4,
    localparam int I64 = (N64 > 1) ? $clog2(N64) : 1,
    localparam int I32 = (N32 > 1) ? $clog2(N32) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_hi,
    input  logic           wr_lo,
    input  logic [I64-1:0] idx64,
    input  logic [63:0]    wdata64,
    input  logic           wr32,
    input  logic [I32-1:0] idx32,
    input  logic [31:0]    wdata32,
    output logic [63:0]    rd64,
    output logic [31:0]    rd32
);
    logic [63:0] mem64 [N64];
    logic [31:0] mem32 [N32];

    for (genvar g = 0; g < N64; g++) begin : g_r64
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem64[g] <= '0;
            end else if (idx64 == I64'(g)) begin
                if (wr_hi) mem64[g][63:32] <= wdata64[63:32];
                if (wr_lo) mem64[g][31:0]  <= wdata64[31:0];
            end
        end
    end

    for (genvar g = 0; g < N32; g++) begin : g_r32
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          mem32[g] <= '0;
            else if (wr32 && idx32 == I32'(g))   mem32[g] <= wdata32;
        end
    end

    assign rd64 = mem64[idx64];
    assign rd32 = mem32[idx32];
endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
    import regwin_pkg::*;
#(
    parameter int ADDR_W      = 36,
    parameter int WIN_W       = 16,
    parameter int N64         = 4,
    parameter int N32         = 4,
    // must be a multiple of 4*N32
    parameter int OFF32_START = 'h100,
    parameter int OFF_BPTR    = 'h200,
    parameter logic [ADDR_W-WIN_W-1:0] DEF_BASE = 'hFFF1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    output logic              bus_ready,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_we,
    input  logic [63:0]       bus_wdata,
    input  logic              big_endian,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_err,
    output logic [63:0]       resp_rdata
);
    localparam int BASE_W  = ADDR_W - WIN_W;
    localparam int I64     = (N64 > 1) ? $clog2(N64) : 1;
    localparam int I32     = (N32 > 1) ? $clog2(N32) : 1;
    localparam int R64_END = N64 * 8;
    localparam int R32_END = OFF32_START + N32 * 4;
    localparam logic [WIN_W-1:0] BPTR_OFF = WIN_W'(OFF_BPTR);

    state_e              state_q, state_d;
    size_e               sz;
    target_e             tgt;
    logic [BASE_W-1:0]   base_q;
    logic                hit, misalign, size_bad, err, hi_sel, accept, wr_ok;
    logic [WIN_W-1:0]    off;
    logic                wr_hi, wr_lo, wr32;
    logic [63:0]         wdata64, rd64, rd_val;
    logic [31:0]         rd32;

    assign sz = size_e'(bus_size);

    regwin_match #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .DEF_BASE(DEF_BASE)) u_match (
        .addr(bus_addr), .base_ptr(base_q), .hit(hit), .offset(off)
    );

    // Target classification from the window offset
    always_comb begin
        if (int'(off) < R64_END)                                   tgt = T_R64;
        else if (int'(off) >= OFF32_START && int'(off) < R32_END)  tgt = T_R32;
        else if (off[WIN_W-1:2] == BPTR_OFF[WIN_W-1:2])            tgt = T_BPTR;
        else                                                       tgt = T_NONE;
    end

    // Size / alignment legality
    always_comb begin
        unique case (sz)
            SZ_B: misalign = 1'b0;
            SZ_H: misalign = bus_addr[0];
            SZ_W: misalign = |bus_addr[1:0];
            SZ_D: misalign = |bus_addr[2:0];
        endcase
        unique case (tgt)
            T_R64:         size_bad = (sz == SZ_B) || (sz == SZ_H);
            T_R32, T_BPTR: size_bad = (sz != SZ_W);
            T_NONE:        size_bad = 1'b0;
        endcase
    end

    assign err    = hit && (misalign || size_bad);
    assign hi_sel = big_endian ? ~bus_addr[2] : bus_addr[2];
    assign accept = bus_valid && bus_ready;
    assign wr_ok  = accept && hit && !err && bus_we;

    assign wr_hi   = wr_ok && (tgt == T_R64) && ((sz == SZ_D) || hi_sel);
    assign wr_lo   = wr_ok && (tgt == T_R64) && ((sz == SZ_D) || !hi_sel);
    assign wr32    = wr_ok && (tgt == T_R32);
    assign wdata64 = (sz == SZ_D) ? bus_wdata : {bus_wdata[31:0], bus_wdata[31:0]};

    regwin_regfile #(.N64(N64), .N32(N32)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .idx64(off[3 +: I64]), .wdata64(wdata64),
        .wr32(wr32), .idx32(off[2 +: I32]), .wdata32(bus_wdata[31:0]),
        .rd64(rd64), .rd32(rd32)
    );

    // Read data selection
    always_comb begin
        unique case (tgt)
            T_R64:  rd_val = (sz == SZ_D) ? rd64
                           : {32'b0, (hi_sel ? rd64[63:32] : rd64[31:0])};
            T_R32:  rd_val = {32'b0, rd32};
            T_BPTR: rd_val = 64'(base_q);
            T_NONE: rd_val = '0;
        endcase
    end

    // Base pointer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          base_q <= DEF_BASE;
        else if (wr_ok && tgt == T_BPTR)     base_q <= bus_wdata[BASE_W-1:0];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        bus_ready  = (state_q == ST_IDLE);
        resp_valid = (state_q == ST_RESP);
    end

    // Response capture on the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_hit   <= 1'b0;
            resp_err   <= 1'b0;
            resp_rdata <= '0;
        end else if (accept) begin
            resp_hit   <= hit;
            resp_err   <= err;
            resp_rdata <= (hit && !err && !bus_we) ? rd_val : '0;
        end
    end
endmodule

// File: rtl/regwin_decoder_chk.sv
module regwin_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_ready,
    input logic [2:0]  addr_lo,
    input logic [1:0]  bus_size,
    input logic        resp_valid,
    input logic        resp_hit,
    input logic        resp_err,
    input logic [63:0] resp_rdata
);
    assert_accept_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready) |=> resp_valid);

    assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && bus_ready));

    assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (!resp_err && resp_rdata == 64'd0));

    assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> (resp_hit && resp_rdata == 64'd0));

    assert_word_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_size == 2'd2) |=> (resp_rdata[63:32] == 32'd0));

    assert_dword_misalign_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_size == 2'd3 && addr_lo != 3'd0)
            |=> (resp_err || !resp_hit));
endmodule

bind regwin_decoder regwin_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .addr_lo(bus_addr[2:0]), .bus_size(bus_size), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_err(resp_err), .resp_rdata(resp_rdata)
);

// File: tb/regwin_decoder_test.sv
`timescale 1ns/1ps
module regwin_decoder_test;
    localparam logic [19:0] DEFB = 20'hFFF1F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_ready;
    logic [35:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_we = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic        big_endian = 1'b0;
    logic        resp_valid, resp_hit, resp_err;
    logic [63:0] resp_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] m64 [4];
    logic [31:0] m32 [4];
    logic [19:0] mbase;

    always #2.5 clk = ~clk;

    regwin_decoder uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .big_endian(big_endian), .resp_valid(resp_valid),
        .resp_hit(resp_hit), .resp_err(resp_err), .resp_rdata(resp_rdata)
    );

    function automatic logic [35:0] at(input logic [19:0] b, input int off);
        return {b, 16'(off)};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference behaviour computed from the requirements
    task automatic model(input logic [35:0] a, input logic [1:0] sz, input logic we,
                         input logic [63:0] wd, output logic eh, output logic ee,
                         output logic [63:0] er);
        int off;
        int kind;
        int i;
        logic mis, bad, upper;
        off = int'(a[15:0]);
        eh  = (a[35:16] == DEFB) || (a[35:16] == mbase);
        kind = 0; i = 0;
        if (off < 32)                    begin kind = 1; i = off / 8; end
        else if (off >= 256 && off < 272) begin kind = 2; i = (off - 256) / 4; end
        else if (off / 4 == 128)          kind = 3;
        mis = (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 0) || (sz == 2'd3 && a[2:0] != 0);
        bad = (kind == 1 && sz < 2'd2) || (kind >= 2 && sz != 2'd2);
        ee  = eh && (mis || bad);
        upper = big_endian ? !a[2] : a[2];
        er = '0;
        if (eh && !ee) begin
            if (!we) begin
                case (kind)
                    1: er = (sz == 2'd3) ? m64[i] : {32'd0, (upper ? m64[i][63:32] : m64[i][31:0])};
                    2: er = {32'd0, m32[i]};
                    3: er = {44'd0, mbase};
                    default: er = '0;
                endcase
            end else begin
                case (kind)
                    1: if (sz == 2'd3) m64[i] = wd;
                       else if (upper) m64[i][63:32] = wd[31:0];
                       else            m64[i][31:0]  = wd[31:0];
                    2: m32[i] = wd[31:0];
                    3: mbase = wd[19:0];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic acc(input logic [35:0] a, input logic [1:0] sz, input logic we,
                       input logic [63:0] wd, input string req);
        logic eh, ee;
        logic [63:0] er;
        model(a, sz, we, wd, eh, ee, er);
        bus_addr = a; bus_size = sz; bus_we = we; bus_wdata = wd; bus_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R11", "resp_valid", 64'(resp_valid), 64'd1);
        chk("R11", "bus_ready in response", 64'(bus_ready), 64'd0);
        chk(req, "hit", 64'(resp_hit), 64'(eh));
        chk(req, "err", 64'(resp_err), 64'(ee));
        chk(req, "rdata", resp_rdata, er);
        @(posedge clk);
        @(negedge clk);
        chk("R11", "resp_valid drops", 64'(resp_valid), 64'd0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) begin m64[k] = '0; m32[k] = '0; end
        mbase = DEFB;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "resp_valid after reset", 64'(resp_valid), 64'd0);
        chk("R1", "bus_ready after reset", 64'(bus_ready), 64'd1);
        acc(at(DEFB, 'h200), 2'd2, 1'b0, '0, "R1");
        for (int r = 0; r < 4; r++) acc(at(DEFB, r * 8), 2'd3, 1'b0, '0, "R1");
        for (int j = 0; j < 4; j++) acc(at(DEFB, 'h100 + 4 * j), 2'd2, 1'b0, '0, "R1");

        // R6, R7, R8: full and half access to 64-bit registers in both byte orders
        for (int e = 0; e < 2; e++) begin
            big_endian = e[0];
            for (int r = 0; r < 4; r++) begin
                acc(at(DEFB, r * 8), 2'd3, 1'b1, 64'h1111_0000_2222_0000 + 64'(e * 16 + r), "R6");
                acc(at(DEFB, r * 8), 2'd3, 1'b0, '0, "R6");
                acc(at(DEFB, r * 8), 2'd2, 1'b0, '0, e ? "R7" : "R8");
                acc(at(DEFB, r * 8 + 4), 2'd2, 1'b0, '0, e ? "R7" : "R8");
                acc(at(DEFB, r * 8), 2'd2, 1'b1, 64'hFFFF_FFFF_A5A5_0000 + 64'(r), e ? "R7" : "R8");
                acc(at(DEFB, r * 8 + 4), 2'd2, 1'b1, 64'h0000_0000_5A5A_0000 + 64'(r), e ? "R7" : "R8");
                acc(at(DEFB, r * 8), 2'd3, 1'b0, '0, e ? "R7" : "R8");
            end
        end

        // R9: 32-bit registers, every size code
        big_endian = 1'b1;
        for (int j = 0; j < 4; j++) begin
            acc(at(DEFB, 'h100 + 4 * j), 2'd2, 1'b1, 64'hDEAD_0000_C0DE_0000 + 64'(j), "R9");
            for (int s = 0; s < 4; s++)
                acc(at(DEFB, 'h100 + 4 * j), 2'(s), 1'b1, 64'h0BAD_0BAD, "R9");
            acc(at(DEFB, 'h100 + 4 * j), 2'd2, 1'b0, '0, "R9");
        end

        // R10: misalignment and narrow access to a 64-bit register
        acc(at(DEFB, 8 + 4), 2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R10");
        acc(at(DEFB, 8 + 2), 2'd2, 1'b1, 64'hFFFF_FFFF, "R10");
        acc(at(DEFB, 8), 2'd1, 1'b1, 64'hFFFF, "R10");
        acc(at(DEFB, 8), 2'd0, 1'b1, 64'hFF, "R10");
        acc(at(DEFB, 'h81), 2'd1, 1'b0, '0, "R10");
        acc(at(DEFB, 8), 2'd3, 1'b0, '0, "R10");

        // R12: unmapped offset inside the window
        acc(at(DEFB, 'h80), 2'd3, 1'b1, 64'h1234, "R12");
        acc(at(DEFB, 'h80), 2'd3, 1'b0, '0, "R12");
        acc(at(DEFB, 'h300), 2'd2, 1'b0, '0, "R12");

        // R3: outside both windows, and the register it would alias is untouched
        acc(at(20'h01234, 0), 2'd3, 1'b1, 64'hAAAA, "R3");
        acc(at(20'h01234, 0), 2'd3, 1'b0, '0, "R3");
        acc(at(DEFB, 0), 2'd3, 1'b0, '0, "R3");

        // R4, R5: relocate the base and reach registers through both aliases
        acc(at(DEFB, 'h200), 2'd2, 1'b1, 64'hFFF0_0ABC, "R4");
        acc(at(20'h00ABC, 'h200), 2'd2, 1'b0, '0, "R4");
        acc(at(DEFB, 'h200), 2'd2, 1'b0, '0, "R4");
        for (int r = 0; r < 4; r++) begin
            acc(at(20'h00ABC, r * 8), 2'd3, 1'b1, 64'h5555_0000_0000_7777 + 64'(r), "R5");
            acc(at(DEFB, r * 8), 2'd3, 1'b0, '0, "R5");
            acc(at(20'h00ABC, r * 8), 2'd3, 1'b0, '0, "R5");
        end
        acc(at(DEFB, 'h104), 2'd2, 1'b1, 64'h600D, "R5");
        acc(at(20'h00ABC, 'h104), 2'd2, 1'b0, '0, "R5");
        acc(at(20'h00ABD, 0), 2'd3, 1'b0, '0, "R3");
        acc(at(DEFB, 0), 2'd3, 1'b0, '0, "R2");

        done = 1'b1;
        summary();
    end
endmodule